// File: doc/BRIEF.md
# Locked-Rotor Detector with Latched Fault

This block watches the three rotor position sensor bits of a brushless motor controller and decides when the rotor has stopped turning, or is only rocking back and forth. A timer counts ticks of a slow timebase. Each rotor step in the expected direction restarts the timer. If a set number of ticks pass without a proper step, the block raises a latched fault that the gate-drive logic uses to switch the bridge off.

A step to any state other than the expected successor sets a sequence-error flag. While that flag is set, further steps do not restart the timer. A rotor that flips between two neighbouring states therefore still reaches the timeout. A step in the expected direction clears the flag. Only the next proper step after that restarts the timer.

The latched fault is cleared in four ways: a change of the direction input, a reset, the disable input, or the output-off request (`enb_off_i`) held high for a set number of ticks. Braking holds the timer at zero. A disable input stands in for grounding the timebase and switches detection off.

Top module: `rotor_lock_guard`

## Requirements
- R1: After reset, `fault_o` and `seq_bad_o` are 0.
- R2: The sensor code is `{C,B,A}` on `hall_i`. With `dir_i`=1 the expected order is 001, 011, 010, 110, 100, 101, then back to 001. With `dir_i`=0 the order is the reverse. A change of `hall_i` to the expected successor of the previous code restarts the lock timer, provided `seq_bad_o` is 0.
- R3: The lock timer counts `tick_i` pulses since its last restart. `fault_o` rises on the clock edge that samples the 127th tick and stays 0 after 126 ticks.
- R4: A change of `hall_i` to any code other than the expected successor sets `seq_bad_o` on the next clock edge. This includes the codes 000 and 111, which are never a successor. Such a change does not restart the timer. An expected step while `seq_bad_o` is 1 clears the flag without restarting the timer, so a rotor bouncing between two codes still faults.
- R5: Once set, `fault_o` stays 1 whatever `hall_i` and `tick_i` do, until one of the clear conditions occurs.
- R6: Any change of `dir_i` clears `fault_o` and `seq_bad_o` on the next edge and restarts the lock timer.
- R7: `enb_off_i` held high for 64 ticks clears `fault_o` and `seq_bad_o` on the edge of the 64th tick. This also restarts the lock timer. Any cycle with `enb_off_i` low restarts the 64-tick count.
- R8: While `brake_n_i` is 0 the lock timer is held at zero and no fault can be raised. A fault that is already set stays set.
- R9: While `lock_dis_i` is 1, `fault_o` and `seq_bad_o` are cleared and the lock timer is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| tick_i | input | 1 | One-cycle timebase tick |
| hall_i | input | 3 | Rotor sensor code `{C,B,A}` |
| dir_i | input | 1 | Rotation direction, 1 = forward |
| enb_off_i | input | 1 | Output-off request, high = drivers off |
| brake_n_i | input | 1 | Active-low brake |
| lock_dis_i | input | 1 | Lock detection disable |
| fault_o | output | 1 | Latched locked-rotor fault |
| seq_bad_o | output | 1 | Wrong-sequence flag |

## Verification
Every input is registered once before it takes effect. A change on `hall_i`, `dir_i`, `lock_dis_i` or `brake_n_i` therefore shows up on the outputs after the first rising edge that samples it. A tick that completes the lock or clear count acts on that same edge.

The bench drives inputs on the falling edge. For each expected value it queues an entry, and the monitor compares the entry 2 ns after the next rising edge, when the result is due. Tick counts are exact, so each boundary is checked one tick before and on the tick where the output must change.

// File: rtl/rlg_pkg.sv
package rlg_pkg;
  localparam int HALL_W = 3;
  typedef logic [HALL_W-1:0] hall_t;

  // a code is legal when it is neither all-zero nor all-one
  function automatic logic hall_ok(hall_t h);
    return (h != 3'b000) && (h != 3'b111);
  endfunction

  // successor of a legal code for the given direction (1 = forward)
  function automatic hall_t hall_next(hall_t h, logic fwd);
    hall_t n;
    if (fwd) begin
      case (h)
        3'b001:  n = 3'b011;
        3'b011:  n = 3'b010;
        3'b010:  n = 3'b110;
        3'b110:  n = 3'b100;
        3'b100:  n = 3'b101;
        3'b101:  n = 3'b001;
        default: n = 3'b000;
      endcase
    end else begin
      case (h)
        3'b001:  n = 3'b101;
        3'b101:  n = 3'b100;
        3'b100:  n = 3'b110;
        3'b110:  n = 3'b010;
        3'b010:  n = 3'b011;
        3'b011:  n = 3'b001;
        default: n = 3'b000;
      endcase
    end
    return n;
  endfunction
endpackage

// File: rtl/rlg_hall_track.sv
module rlg_hall_track
  import rlg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  hall_t hall_i,
  input  logic  dir_i,
  input  logic  flush_i,
  output logic  good_o,
  output logic  bad_o,
  output logic  seq_bad_o
);
  hall_t hall_q;
  logic  live_q;
  logic  seq_q;
  logic  moved;

  assign moved  = live_q && (hall_i != hall_q);
  assign good_o = moved && hall_ok(hall_q) && (hall_i == hall_next(hall_q, dir_i));
  assign bad_o  = moved && !good_o;
  assign seq_bad_o = seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hall_q <= '0;
      live_q <= 1'b0;
      seq_q  <= 1'b0;
    end else begin
      live_q <= 1'b1;
      hall_q <= hall_i;
      if (flush_i)     seq_q <= 1'b0;
      else if (bad_o)  seq_q <= 1'b1;
      else if (good_o) seq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rlg_tick_timer.sv
module rlg_tick_timer #(
  parameter int LIMIT = 127
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign done_o = tick_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (tick_i && (cnt_q != TOP)) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rotor_lock_guard.sv
module rotor_lock_guard #(
  parameter int LOCK_TICKS  = 127,
  parameter int CLEAR_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [2:0] hall_i,
  input  logic       dir_i,
  input  logic       enb_off_i,
  input  logic       brake_n_i,
  input  logic       lock_dis_i,
  output logic       fault_o,
  output logic       seq_bad_o
);
  logic dir_q, live_q, fault_q;
  logic hall_good, hall_bad;
  logic dir_edge, restart, flush, lock_clr;
  logic lock_done, clear_done;

  assign dir_edge = live_q && (dir_i != dir_q);
  assign restart  = hall_good && !seq_bad_o;
  assign flush    = dir_edge || clear_done || lock_dis_i;
  assign lock_clr = restart || flush || !brake_n_i || fault_q;

  rlg_hall_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .hall_i    (hall_i),
    .dir_i     (dir_i),
    .flush_i   (flush),
    .good_o    (hall_good),
    .bad_o     (hall_bad),
    .seq_bad_o (seq_bad_o)
  );

  rlg_tick_timer #(.LIMIT(LOCK_TICKS)) u_lock_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (lock_clr),
    .tick_i (tick_i),
    .done_o (lock_done)
  );

  rlg_tick_timer #(.LIMIT(CLEAR_TICKS)) u_clear_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!enb_off_i),
    .tick_i (tick_i),
    .done_o (clear_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      live_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      dir_q  <= dir_i;
      live_q <= 1'b1;
      if (flush)          fault_q <= 1'b0;
      else if (lock_done) fault_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/rlg_checker.sv
module rlg_checker (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic dir_i,
  input logic enb_off_i,
  input logic brake_n_i,
  input logic lock_dis_i,
  input logic fault_o,
  input logic seq_bad_o,
  input logic hall_bad
);
  p_trip_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(tick_i));

  p_brake_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !brake_n_i |=> !$rose(fault_o));

  p_dis_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_dis_i |=> (!fault_o && !seq_bad_o));

  p_dir_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dir_i) && $past(rst_n)) |=> !fault_o);

  p_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && $stable(dir_i) && !lock_dis_i && !enb_off_i) |=> fault_o);

  p_bad_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hall_bad && $stable(dir_i) && !lock_dis_i && !enb_off_i) |=> seq_bad_o);
endmodule

bind rotor_lock_guard rlg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .dir_i      (dir_i),
  .enb_off_i  (enb_off_i),
  .brake_n_i  (brake_n_i),
  .lock_dis_i (lock_dis_i),
  .fault_o    (fault_o),
  .seq_bad_o  (seq_bad_o),
  .hall_bad   (hall_bad)
);

// File: tb/tb_rotor_lock_guard.sv
module tb_rotor_lock_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic [2:0] hall_i = 3'b001;
  logic       dir_i = 1'b1;
  logic       enb_off_i = 1'b0;
  logic       brake_n_i = 1'b1;
  logic       lock_dis_i = 1'b0;
  logic       fault_o, seq_bad_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { string req; bit f; bit s; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  rotor_lock_guard dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hall_i(hall_i),
    .dir_i(dir_i), .enb_off_i(enb_off_i), .brake_n_i(brake_n_i),
    .lock_dis_i(lock_dis_i), .fault_o(fault_o), .seq_bad_o(seq_bad_o)
  );

  // monitor: compares queued expectations 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (fault_o !== e.f || seq_bad_o !== e.s) begin
          fails++;
          $display("FAIL %s: fault=%b seq=%b expected fault=%b seq=%b",
                   e.req, fault_o, seq_bad_o, e.f, e.s);
        end
      end
    end
  end

  task automatic expect_out(string req, bit f, bit s);
    exp_t e;
    e.req = req; e.f = f; e.s = s;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic set_hall(logic [2:0] h);
    @(negedge clk); hall_i = h;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_out("R1 reset", 1'b0, 1'b0);
    repeat (2) @(negedge clk);

    // R2/R3: proper forward steps restart the timer
    set_hall(3'b011);
    expect_out("R2 good step", 1'b0, 1'b0);
    ticks(126);
    expect_out("R3 126 ticks no fault", 1'b0, 1'b0);
    set_hall(3'b010);
    expect_out("R2 restart", 1'b0, 1'b0);
    ticks(126);
    expect_out("R2 restarted timer holds off", 1'b0, 1'b0);
    ticks(1);
    expect_out("R3 127th tick trips", 1'b1, 1'b0);

    // R5: latched despite good steps and ticks
    set_hall(3'b110);
    expect_out("R5 latched on step", 1'b1, 1'b0);
    ticks(10);
    expect_out("R5 latched on ticks", 1'b1, 1'b0);

    // R6: direction change clears
    @(negedge clk); dir_i = 1'b0;
    expect_out("R6 dir edge clears", 1'b0, 1'b0);

    // R4: reverse step, then bounce between two codes
    set_hall(3'b010);
    expect_out("R4 reverse good step", 1'b0, 1'b0);
    ticks(60);
    set_hall(3'b110);
    expect_out("R4 wrong step flags", 1'b0, 1'b1);
    ticks(30);
    set_hall(3'b010);
    expect_out("R4 good step clears flag", 1'b0, 1'b0);
    set_hall(3'b110);
    expect_out("R4 flag again", 1'b0, 1'b1);
    ticks(36);
    expect_out("R4 bounce 126 ticks", 1'b0, 1'b1);
    ticks(1);
    expect_out("R4 bounce trips", 1'b1, 1'b1);

    // R7: output-off held for the clear window
    @(negedge clk); enb_off_i = 1'b1;
    ticks(63);
    expect_out("R7 63 ticks still latched", 1'b1, 1'b1);
    @(negedge clk); enb_off_i = 1'b0;
    @(negedge clk); enb_off_i = 1'b1;
    ticks(63);
    expect_out("R7 low cycle restarts count", 1'b1, 1'b1);
    ticks(1);
    expect_out("R7 64th tick clears", 1'b0, 1'b0);
    @(negedge clk); enb_off_i = 1'b0;

    // R8: brake holds the timer
    @(negedge clk); brake_n_i = 1'b0;
    ticks(130);
    expect_out("R8 no fault under brake", 1'b0, 1'b0);
    @(negedge clk); brake_n_i = 1'b1;
    ticks(126);
    expect_out("R8 timer was held at zero", 1'b0, 1'b0);
    ticks(1);
    expect_out("R8 trips after release", 1'b1, 1'b0);
    @(negedge clk); brake_n_i = 1'b0;
    expect_out("R8 fault kept under brake", 1'b1, 1'b0);
    @(negedge clk); brake_n_i = 1'b1;

    // R9: disable clears and holds
    @(negedge clk); lock_dis_i = 1'b1;
    expect_out("R9 disable clears", 1'b0, 1'b0);
    ticks(130);
    expect_out("R9 no fault while disabled", 1'b0, 1'b0);
    @(negedge clk); lock_dis_i = 1'b0;
    ticks(126);
    expect_out("R9 timer held at zero", 1'b0, 1'b0);
    ticks(1);
    expect_out("R9 trips after enable", 1'b1, 1'b0);

    // R6 again, then illegal codes (R4)
    @(negedge clk); dir_i = 1'b1;
    expect_out("R6 second dir edge clears", 1'b0, 1'b0);
    set_hall(3'b111);
    expect_out("R4 code 111 flags", 1'b0, 1'b1);
    set_hall(3'b100);
    expect_out("R4 step from 111 stays flagged", 1'b0, 1'b1);

    done = 1'b1;
    finish_run();
  end
endmodule